// File: doc/BRIEF.md
# SAD Block-Matching Search Engine

This engine finds where a small reference block best fits inside a larger image frame. Both pixel arrays live in external synchronous memories with a one-cycle read latency. The frame memory and the block memory each have their own read port. Each array is stored row by row as a flat array that starts at address zero.

On a start pulse the engine captures the four dimensions. It then visits every candidate placement of the block inside the frame, in a zigzag order across anti-diagonals. At each placement it sums the absolute differences of all aligned pixel pairs, reading one pair per cycle. It keeps the lowest sum it has seen. When the scan ends it presents the row and column of the winning placement with its cost, and pulses done.

Addresses are produced by counters that only add or subtract. The engine has no multiplier, divider or modulo unit.

Top module: `sad_search`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `best_row`, `best_col` and `best_sad` are 0.
- R2: The cost of a placement at (r,c) is the sum over all block pixels (i,j) of |F[(r+i)*FW+(c+j)] − B[i*BW+j]|. Pixels are 8-bit unsigned, and `best_sad` is 20 bits, so the largest cost of 64×64×255 does not wrap.
- R3: `best_sad` equals the lowest cost over all placements. `best_row` and `best_col` give the placement that reaches it.
- R4: On equal costs, the placement visited first in zigzag order wins. The zigzag starts at (0,0). It walks anti-diagonal d=r+c for d = 0, 1, 2, and so on. Even d is walked with r descending and odd d with r ascending, which ends at the bottom-right placement.
- R5: The placements form a grid of (FH−BH+1) rows by (FW−BW+1) columns. This holds for a block as large as the frame (one placement), for a 1×1 block, and for non-square frames with sides from 16 to 64.
- R6: The frame read address is (r+i)*FW+(c+j) and the block read address is i*BW+j. Neither ever goes outside its array.
- R7: `done` is a one-cycle pulse that comes P*(BW*BH+3) rising edges after the edge that samples `start`, where P is the number of placements. `busy` is high from the edge after `start` until the edge after `done`, and low after that.
- R8: The dimensions are sampled only with `start` while idle. A `start` pulse or a change of dimensions during a search does not affect its result or its timing.
- R9: While idle and with no `start`, `best_row`, `best_col` and `best_sad` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a search when the engine is idle |
| frm_w | input | 7 | Frame width FW (16..64) |
| frm_h | input | 7 | Frame height FH (16..64) |
| blk_w | input | 7 | Block width BW (1..FW) |
| blk_h | input | 7 | Block height BH (1..FH) |
| frm_addr | output | 12 | Frame memory read address |
| frm_data | input | 8 | Frame pixel, valid one cycle after its address |
| blk_addr | output | 12 | Block memory read address |
| blk_data | input | 8 | Block pixel, valid one cycle after its address |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| best_row | output | 7 | Row of the best placement |
| best_col | output | 7 | Column of the best placement |
| best_sad | output | 20 | Cost of the best placement |

## Verification
Most internal faults show at the ports only once the search ends, through the latency of `done` and the three result values.

- A wrong zigzag step either skips placements or repeats them. This changes the cycle on which `done` fires, and it changes the winner when costs tie.
- A stale row pointer shows as a wrong `best_sad` after the scan.
- A lost accumulate cycle shows as a wrong `best_sad` after the scan.

Planted exact matches, uniform frames that force ties, and cost-saturating fills make each of these faults show as a different value.

// File: rtl/sad_pkg.sv
package sad_pkg;
  parameter int PIX_W  = 8;
  parameter int DIM_W  = 7;
  parameter int ADDR_W = 12;
  parameter int SAD_W  = 20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN,
    ST_DRAIN,
    ST_EVAL,
    ST_DONE
  } sad_state_t;
endpackage

// File: rtl/sad_zigzag.sv
module sad_zigzag #(
  parameter int DIM_W  = 7,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              step,
  input  logic [DIM_W-1:0]  max_r,
  input  logic [DIM_W-1:0]  max_c,
  input  logic [DIM_W-1:0]  fw,
  output logic [DIM_W-1:0]  row,
  output logic [DIM_W-1:0]  col,
  output logic [ADDR_W-1:0] base,
  output logic              at_end
);
  localparam logic [DIM_W-1:0]  D1 = DIM_W'(1);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);

  logic              up_q, up_d;
  logic [DIM_W-1:0]  row_d, col_d;
  logic [ADDR_W-1:0] base_d, fw_x;

  assign fw_x   = ADDR_W'(fw);
  assign at_end = (row == max_r) && (col == max_c);

  // next placement: edge rules take priority over the diagonal move
  always_comb begin
    row_d  = row;
    col_d  = col;
    base_d = base;
    up_d   = up_q;
    if (init) begin
      row_d  = '0;
      col_d  = '0;
      base_d = '0;
      up_d   = 1'b1;
    end else if (step) begin
      if (up_q) begin
        if (col == max_c) begin
          row_d = row + D1; base_d = base + fw_x; up_d = 1'b0;
        end else if (row == '0) begin
          col_d = col + D1; base_d = base + A1; up_d = 1'b0;
        end else begin
          row_d = row - D1; col_d = col + D1; base_d = base + A1 - fw_x;
        end
      end else begin
        if (row == max_r) begin
          col_d = col + D1; base_d = base + A1; up_d = 1'b1;
        end else if (col == '0) begin
          row_d = row + D1; base_d = base + fw_x; up_d = 1'b1;
        end else begin
          row_d = row + D1; col_d = col - D1; base_d = base + fw_x - A1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row  <= '0;
      col  <= '0;
      base <= '0;
      up_q <= 1'b1;
    end else if (init || step) begin
      row  <= row_d;
      col  <= col_d;
      base <= base_d;
      up_q <= up_d;
    end
  end
endmodule

// File: rtl/sad_addr_gen.sv
module sad_addr_gen #(
  parameter int DIM_W  = 7,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] pos_base,
  input  logic [DIM_W-1:0]  fw,
  input  logic [DIM_W-1:0]  ww,
  input  logic [DIM_W-1:0]  wh,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [ADDR_W-1:0] blk_addr,
  output logic              last_pix
);
  localparam logic [DIM_W-1:0]  D1 = DIM_W'(1);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);

  logic [DIM_W-1:0]  j_q, j_d, i_q, i_d, ww_m1, wh_m1;
  logic [ADDR_W-1:0] rp_q, rp_d, bp_q, bp_d;

  assign ww_m1    = ww - D1;
  assign wh_m1    = wh - D1;
  assign last_pix = (j_q == ww_m1) && (i_q == wh_m1);
  assign frm_addr = rp_q + ADDR_W'(j_q);
  assign blk_addr = bp_q;

  always_comb begin
    j_d  = j_q;
    i_d  = i_q;
    rp_d = rp_q;
    bp_d = bp_q;
    if (load) begin
      j_d  = '0;
      i_d  = '0;
      rp_d = pos_base;
      bp_d = '0;
    end else if (adv) begin
      bp_d = bp_q + A1;
      if (j_q == ww_m1) begin
        j_d  = '0;
        i_d  = i_q + D1;
        rp_d = rp_q + ADDR_W'(fw);
      end else begin
        j_d = j_q + D1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      j_q  <= '0;
      i_q  <= '0;
      rp_q <= '0;
      bp_q <= '0;
    end else if (load || adv) begin
      j_q  <= j_d;
      i_q  <= i_d;
      rp_q <= rp_d;
      bp_q <= bp_d;
    end
  end
endmodule

// File: rtl/sad_accum.sv
module sad_accum #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PIX_W-1:0] a,
  input  logic [PIX_W-1:0] b,
  output logic [SAD_W-1:0] sum
);
  logic [PIX_W-1:0] diff;
  logic [SAD_W-1:0] sum_d;

  assign diff = (a >= b) ? (a - b) : (b - a);

  always_comb begin
    sum_d = sum;
    if (clr)     sum_d = '0;
    else if (en) sum_d = sum + SAD_W'(diff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sum <= '0;
    else if (clr || en) sum <= sum_d;
  end
endmodule

// File: rtl/sad_search.sv
module sad_search
  import sad_pkg::*;
#(
  parameter int P_PIX  = PIX_W,
  parameter int P_DIM  = DIM_W,
  parameter int P_ADDR = ADDR_W,
  parameter int P_SAD  = SAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [P_DIM-1:0]  frm_w,
  input  logic [P_DIM-1:0]  frm_h,
  input  logic [P_DIM-1:0]  blk_w,
  input  logic [P_DIM-1:0]  blk_h,
  output logic [P_ADDR-1:0] frm_addr,
  input  logic [P_PIX-1:0]  frm_data,
  output logic [P_ADDR-1:0] blk_addr,
  input  logic [P_PIX-1:0]  blk_data,
  output logic              busy,
  output logic              done,
  output logic [P_DIM-1:0]  best_row,
  output logic [P_DIM-1:0]  best_col,
  output logic [P_SAD-1:0]  best_sad
);
  sad_state_t state, state_d;

  logic [P_DIM-1:0]  fw_q, fh_q, ww_q, wh_q, max_r, max_c, zz_row, zz_col;
  logic [P_ADDR-1:0] zz_base;
  logic [P_SAD-1:0]  acc_sum;
  logic              rd_vld, first_q, zz_end, last_pix, issue, take, launch;

  assign max_r  = fh_q - wh_q;
  assign max_c  = fw_q - ww_q;
  assign issue  = (state == ST_RUN);
  assign launch = (state == ST_IDLE) && start;
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_DONE);
  assign take   = (state == ST_EVAL) && (first_q || (acc_sum < best_sad));

  sad_zigzag #(.DIM_W(P_DIM), .ADDR_W(P_ADDR)) u_zz (
    .clk(clk), .rst_n(rst_n), .init(launch),
    .step((state == ST_EVAL) && !zz_end),
    .max_r(max_r), .max_c(max_c), .fw(fw_q),
    .row(zz_row), .col(zz_col), .base(zz_base), .at_end(zz_end)
  );

  sad_addr_gen #(.DIM_W(P_DIM), .ADDR_W(P_ADDR)) u_ag (
    .clk(clk), .rst_n(rst_n), .load(state == ST_SETUP), .adv(issue),
    .pos_base(zz_base), .fw(fw_q), .ww(ww_q), .wh(wh_q),
    .frm_addr(frm_addr), .blk_addr(blk_addr), .last_pix(last_pix)
  );

  sad_accum #(.PIX_W(P_PIX), .SAD_W(P_SAD)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_SETUP), .en(rd_vld),
    .a(frm_data), .b(blk_data), .sum(acc_sum)
  );

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:  if (start) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_RUN;
      ST_RUN:   if (last_pix) state_d = ST_DRAIN;
      ST_DRAIN: state_d = ST_EVAL;
      ST_EVAL:  state_d = zz_end ? ST_DONE : ST_SETUP;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rd_vld <= 1'b0;
    end else begin
      state  <= state_d;
      rd_vld <= issue;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_q <= '0; fh_q <= '0; ww_q <= '0; wh_q <= '0;
    end else if (launch) begin
      fw_q <= frm_w; fh_q <= frm_h; ww_q <= blk_w; wh_q <= blk_h;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              first_q <= 1'b0;
    else if (launch)         first_q <= 1'b1;
    else if (state == ST_EVAL) first_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_row <= '0;
      best_col <= '0;
      best_sad <= '0;
    end else if (take) begin
      best_row <= zz_row;
      best_col <= zz_col;
      best_sad <= acc_sum;
    end
  end
endmodule

// File: rtl/sad_search_chk.sv
module sad_search_chk #(
  parameter int DW = 7,
  parameter int AW = 12,
  parameter int SW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          issue,
  input logic [AW-1:0] frm_addr,
  input logic [AW-1:0] blk_addr,
  input logic [DW-1:0] fw,
  input logic [DW-1:0] fh,
  input logic [DW-1:0] ww,
  input logic [DW-1:0] wh,
  input logic [DW-1:0] row,
  input logic [DW-1:0] col,
  input logic [DW-1:0] max_r,
  input logic [DW-1:0] max_c,
  input logic [DW-1:0] best_row,
  input logic [DW-1:0] best_col,
  input logic [SW-1:0] best_sad
);
  AST_FRM_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (32'(frm_addr) < 32'(fw) * 32'(fh)));  // R6
  AST_BLK_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (32'(blk_addr) < 32'(ww) * 32'(wh)));  // R6
  AST_POS_IN_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> (row <= max_r && col <= max_c));  // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));  // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);  // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(best_sad) && $stable(best_row) && $stable(best_col)));  // R9
endmodule

bind sad_search sad_search_chk #(.DW(P_DIM), .AW(P_ADDR), .SW(P_SAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .issue(issue), .frm_addr(frm_addr), .blk_addr(blk_addr),
  .fw(fw_q), .fh(fh_q), .ww(ww_q), .wh(wh_q),
  .row(zz_row), .col(zz_col), .max_r(max_r), .max_c(max_c),
  .best_row(best_row), .best_col(best_col), .best_sad(best_sad)
);

// File: tb/tb_sad_search.sv
module tb_sad_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  frm_w = 7'd16, frm_h = 7'd16, blk_w = 7'd1, blk_h = 7'd1;
  logic [11:0] frm_addr, blk_addr;
  logic [7:0]  frm_data, blk_data;
  logic        busy, done;
  logic [6:0]  best_row, best_col;
  logic [19:0] best_sad;

  logic [7:0] fmem [0:4095];
  logic [7:0] bmem [0:4095];

  int checks = 0;
  int errors = 0;
  int tick   = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  always_ff @(posedge clk) begin
    frm_data <= fmem[frm_addr];
    blk_data <= bmem[blk_addr];
  end

  sad_search dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .frm_w(frm_w), .frm_h(frm_h), .blk_w(blk_w), .blk_h(blk_h),
    .frm_addr(frm_addr), .frm_data(frm_data),
    .blk_addr(blk_addr), .blk_data(blk_data),
    .busy(busy), .done(done),
    .best_row(best_row), .best_col(best_col), .best_sad(best_sad)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cost(input int fw, input int bw, input int bh,
                              input int r, input int c);
    int s = 0;
    for (int i = 0; i < bh; i++)
      for (int j = 0; j < bw; j++) begin
        int a = fmem[(r + i) * fw + c + j];
        int b = bmem[i * bw + j];
        s += (a > b) ? a - b : b - a;
      end
    return s;
  endfunction

  task automatic model(input int fw, input int fh, input int bw, input int bh,
                       output int er, output int ec, output int es);
    int mr = fh - bh;
    int mc = fw - bw;
    bit first = 1'b1;
    er = 0; ec = 0; es = 0;
    for (int d = 0; d <= mr + mc; d++) begin
      int lo = (d > mc) ? d - mc : 0;
      int hi = (d < mr) ? d : mr;
      for (int k = 0; k <= hi - lo; k++) begin
        int r = (d % 2 == 0) ? hi - k : lo + k;
        int c = d - r;
        int s = cost(fw, bw, bh, r, c);
        if (first || s < es) begin
          er = r; ec = c; es = s; first = 1'b0;
        end
      end
    end
  endtask

  task automatic run(input int fw, input int fh, input int bw, input int bh,
                     input bit poke, input string tag);
    int er, ec, es, cyc, exp_lat;
    bit seen;
    model(fw, fh, bw, bh, er, ec, es);
    exp_lat = (fh - bh + 1) * (fw - bw + 1) * (bw * bh + 3);
    @(negedge clk);
    frm_w = 7'(fw); frm_h = 7'(fh); blk_w = 7'(bw); blk_h = 7'(bh);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    seen = 1'b0;
    while (!seen && cyc < exp_lat + 50) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (poke && cyc == 4) begin
        start = 1'b1;
        frm_w = 7'd17; frm_h = 7'd63; blk_w = 7'd2; blk_h = 7'd9;
      end else begin
        start = 1'b0;
      end
      if (done) seen = 1'b1;
    end
    check({tag, " R7 latency"}, cyc, exp_lat);
    check({tag, " R3 best_sad"}, int'(best_sad), es);
    check({tag, " R4 best_row"}, int'(best_row), er);
    check({tag, " R4 best_col"}, int'(best_col), ec);
    @(negedge clk);
    check({tag, " R7 busy low after done"}, int'(busy), 0);
  endtask

  task automatic fill_rand(input int fw, input int fh, input int bw, input int bh);
    for (int k = 0; k < fw * fh; k++) fmem[k] = 8'($urandom);
    for (int k = 0; k < bw * bh; k++) bmem[k] = 8'($urandom);
  endtask

  task automatic fill_const(input int n_f, input int fv, input int n_b, input int bv);
    for (int k = 0; k < n_f; k++) fmem[k] = 8'(fv);
    for (int k = 0; k < n_b; k++) bmem[k] = 8'(bv);
  endtask

  initial begin
    wait (tick >= 190000);
    errors++;
    checks++;
    $display("FAIL R7 watchdog expired actual=%0d expected=<190000", tick);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int fw, fh, bw, bh, rr, cc;
    int hold_s, hold_r, hold_c;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4096; k++) begin fmem[k] = '0; bmem[k] = '0; end
    #7;
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 best_sad", int'(best_sad), 0);
    check("R1 best_row/col", int'(best_row) + int'(best_col), 0);
    rst_n = 1'b1;

    // R2 R3: random frames and blocks
    for (int t = 0; t < 5; t++) begin
      fw = 16 + int'($urandom % 5);
      fh = 16 + int'($urandom % 5);
      bw = 2 + int'($urandom % 4);
      bh = 2 + int'($urandom % 4);
      fill_rand(fw, fh, bw, bh);
      run(fw, fh, bw, bh, 1'b0, "random R2");
    end

    // R3: planted exact match in noise
    fw = 20; fh = 18; bw = 4; bh = 3;
    fill_rand(fw, fh, bw, bh);
    rr = 9; cc = 13;
    for (int i = 0; i < bh; i++)
      for (int j = 0; j < bw; j++) fmem[(rr + i) * fw + cc + j] = bmem[i * bw + j];
    run(fw, fh, bw, bh, 1'b0, "planted R3");
    check("planted R3 zero cost", int'(best_sad), 0);
    check("planted R3 row", int'(best_row), rr);
    check("planted R3 col", int'(best_col), cc);

    // R4: uniform frame, every placement ties, (0,0) wins
    fill_const(16 * 16, 7, 16, 7);
    run(16, 16, 4, 4, 1'b0, "tie-all R4");
    check("tie-all R4 origin", int'(best_row) * 100 + int'(best_col), 0);

    // R4: two zero-cost spots on diagonal 3, (0,3) comes before (3,0)
    fill_const(16 * 16, 200, 4, 9);
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++) begin
        fmem[(0 + i) * 16 + 3 + j] = 8'd9;
        fmem[(3 + i) * 16 + 0 + j] = 8'd9;
      end
    run(16, 16, 2, 2, 1'b0, "tie-diag R4");
    check("tie-diag R4 row", int'(best_row), 0);
    check("tie-diag R4 col", int'(best_col), 3);

    // R5: block equals frame (single placement) and 1x1 block
    fill_rand(16, 16, 16, 16);
    run(16, 16, 16, 16, 1'b0, "single R5");
    fill_rand(17, 16, 1, 1);
    run(17, 16, 1, 1, 1'b0, "unit R5");

    // R5 R6: non-square frames at the size limits
    fill_rand(64, 16, 60, 2);
    run(64, 16, 60, 2, 1'b0, "wide R6");
    fill_rand(16, 64, 3, 58);
    run(16, 64, 3, 58, 1'b0, "tall R6");

    // R2: largest cost does not wrap
    fill_const(64 * 64, 255, 64 * 64, 0);
    run(64, 64, 64, 64, 1'b0, "max R2");
    check("max R2 full cost", int'(best_sad), 64 * 64 * 255);

    // R8: start and new dimensions mid-search are ignored
    fw = 18; fh = 17; bw = 3; bh = 4;
    fill_rand(fw, fh, bw, bh);
    run(fw, fh, bw, bh, 1'b1, "poke R8");

    // R9: results hold while idle
    hold_s = int'(best_sad); hold_r = int'(best_row); hold_c = int'(best_col);
    frm_w = 7'd40; blk_w = 7'd5;
    repeat (20) @(negedge clk);
    check("R9 hold sad", int'(best_sad), hold_s);
    check("R9 hold row/col", int'(best_row) * 100 + int'(best_col), hold_r * 100 + hold_c);
    check("R9 idle", int'(busy), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule